// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block sits in the feedback path of a fractional-N synthesizer. It divides an input clock by a ratio made of a 12-bit integer part and a 25-bit fraction. The fraction's denominator is fixed at 2^25, so the ratio can be set in steps of 1/2^25. A third-order noise-shaping modulator is built from three cascaded 25-bit accumulators, and its carry outputs are combined into a signed offset. That offset moves the integer divide value of each period by a small amount. Averaged over many periods, the ratio equals the integer part plus the fraction over 2^25.

The output is a single-cycle pulse at the end of every division period, and it goes to the phase detector. New ratio words are captured with a load strobe. They are applied only when the running period ends, so a period is never cut short. An error flag is raised while the active integer word is below the legal minimum of 23. In that case the period is held at a safe floor length so that the counter keeps working.

Top module: `frac_n_fb_div`

## Requirements
- R1: While `rst` is high, `div_pulse` is low and the counter and all three accumulators are cleared. After `rst` is released, the first `div_pulse` appears in clock cycle number INT, where cycle 1 is the first cycle after the last reset edge. The first period carries no fractional offset.
- R2: `div_pulse` is high for exactly one clock cycle per division period. The period length is the number of clock cycles from one pulse to the next.
- R3: Every period length equals the active INT plus a modulator offset that lies between -3 and +4 inclusive.
- R4: Over P consecutive periods, counted from the release of reset, the total number of input clocks is within 4 of P*INT + P*FRAC/2^25.
- R5: While the active FRAC is 0, the offset is 0 and every period is exactly INT clocks long. This also holds at once after FRAC is changed from a nonzero value to 0.
- R6: A high `load` in a cycle captures `int_word` and `frac_word`. The captured values take effect at the first period end after the capturing edge, and the period already running keeps its old length. A load in the cycle where `div_pulse` is high waits one further period.
- R7: `int_err` is high exactly while the active INT is below 23. It changes only at a period end.
- R8: No period is shorter than SAFE_MIN clocks (default 8). With INT = 5 and FRAC = 0, each period is 8 clocks long and `int_err` is high.
- R9: The full word ranges are handled: INT up to 4095 (periods up to 4099 clocks) and FRAC up to 2^25-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock being divided |
| rst | input | 1 | Synchronous reset, active high; also captures the words directly |
| int_word | input | 12 | Integer part of the ratio |
| frac_word | input | 25 | Fraction numerator over 2^25 |
| load | input | 1 | Capture strobe for the two words |
| div_pulse | output | 1 | One-cycle pulse at the end of each division period |
| int_err | output | 1 | High while the active integer word is below 23 |

## Verification
`div_pulse` decodes the counter register directly. It is therefore visible right after the edge that brings the count to zero, and the next edge reloads the count. The bench advances one clock edge at a time and samples 1 ns later, so the edge count between two pulses is exactly the period length. The first pulse is expected after INT edges counted from the last reset edge. A load applied in a given cycle is checked against the length of the period already running, and then against the period that follows. `int_err` is sampled once just before a period end and once in the period after it, because it changes at the same edge that starts the new period.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

  localparam int unsigned OFS_W = 4;
  typedef logic signed [OFS_W-1:0] ofs_t;

  // Third-order cascade recombination: c1 + (1-z)c2 + (1-z)^2 c3
  function automatic ofs_t mash_combine(input logic c1, input logic c2,
                                        input logic c2z, input logic c3,
                                        input logic c3z, input logic c3zz);
    ofs_t s;
    s = $signed({3'b000, c1}) + $signed({3'b000, c2}) - $signed({3'b000, c2z})
      + $signed({3'b000, c3}) - $signed({2'b00, c3z, 1'b0}) + $signed({3'b000, c3zz});
    return s;
  endfunction

  // Period length = base + offset, held at or above a floor
  function automatic int unsigned period_len(input int unsigned base, input ofs_t ofs,
                                             input int unsigned floor_len);
    int n;
    n = $signed(base) + int'(ofs);
    if (n < $signed(floor_len)) n = $signed(floor_len);
    return unsigned'(n);
  endfunction

endpackage

// File: rtl/fnd_ratio_regs.sv
module fnd_ratio_regs #(
  parameter int unsigned INT_W  = 12,
  parameter int unsigned FRAC_W = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              boundary,
  input  logic [INT_W-1:0]  int_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [INT_W-1:0]  eff_int,
  output logic [FRAC_W-1:0] eff_frac,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac
);

  logic [INT_W-1:0]  pend_int;
  logic [FRAC_W-1:0] pend_frac;
  logic              pend_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_int   <= int_in;
      act_frac  <= frac_in;
      pend_int  <= int_in;
      pend_frac <= frac_in;
      pend_vld  <= 1'b0;
    end else begin
      if (boundary && pend_vld) begin
        act_int  <= pend_int;
        act_frac <= pend_frac;
      end
      if (load) begin
        pend_int  <= int_in;
        pend_frac <= frac_in;
        pend_vld  <= 1'b1;
      end else if (boundary) begin
        pend_vld <= 1'b0;
      end
    end
  end

  // Values the next period will use
  always_comb begin
    eff_int  = pend_vld ? pend_int  : act_int;
    eff_frac = pend_vld ? pend_frac : act_frac;
  end

  // R6: active words move only on a period end
  a_r6_boundary_only: assert property (@(posedge clk) disable iff (rst)
    !$stable({act_int, act_frac}) |-> $past(boundary));

endmodule

// File: rtl/fnd_mash3.sv
module fnd_mash3 import fnd_pkg::*; #(
  parameter int unsigned FRAC_W = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac_in,
  output ofs_t              ofs_next
);

  logic [FRAC_W-1:0] acc1_q, acc2_q, acc3_q;
  logic              c2z_q, c3z_q, c3zz_q;
  logic [FRAC_W:0]   sum1, sum2, sum3;
  logic              frac_zero;

  always_comb begin
    sum1      = {1'b0, acc1_q} + {1'b0, frac_in};
    sum2      = {1'b0, acc2_q} + {1'b0, sum1[FRAC_W-1:0]};
    sum3      = {1'b0, acc3_q} + {1'b0, sum2[FRAC_W-1:0]};
    frac_zero = (frac_in == '0);
    ofs_next  = frac_zero ? ofs_t'(0)
              : mash_combine(sum1[FRAC_W], sum2[FRAC_W], c2z_q,
                             sum3[FRAC_W], c3z_q, c3zz_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc1_q <= '0; acc2_q <= '0; acc3_q <= '0;
      c2z_q  <= 1'b0; c3z_q <= 1'b0; c3zz_q <= 1'b0;
    end else if (step) begin
      if (frac_zero) begin
        acc1_q <= '0; acc2_q <= '0; acc3_q <= '0;
        c2z_q  <= 1'b0; c3z_q <= 1'b0; c3zz_q <= 1'b0;
      end else begin
        acc1_q <= sum1[FRAC_W-1:0];
        acc2_q <= sum2[FRAC_W-1:0];
        acc3_q <= sum3[FRAC_W-1:0];
        c2z_q  <= sum2[FRAC_W];
        c3z_q  <= sum3[FRAC_W];
        c3zz_q <= c3z_q;
      end
    end
  end

  // R3: offset stays inside -3..+4
  a_r3_offset_range: assert property (@(posedge clk) disable iff (rst)
    step |-> ((ofs_next >= -4'sd3) && (ofs_next <= 4'sd4)));

  // R5: a zero fraction leaves the cascade empty
  a_r5_quiet_state: assert property (@(posedge clk) disable iff (rst)
    (step && frac_zero) |=> (acc1_q == '0 && acc2_q == '0 && acc3_q == '0));

endmodule

// File: rtl/fnd_cycle_counter.sv
module fnd_cycle_counter #(
  parameter int unsigned CNT_W    = 13,
  parameter int unsigned SAFE_MIN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rst_count,
  input  logic [CNT_W-1:0] reload_count,
  output logic             pulse
);

  localparam logic [CNT_W-1:0] FLOOR_CNT = CNT_W'(SAFE_MIN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= rst_count;
    else if (cnt_q == '0) cnt_q <= reload_count;
    else                  cnt_q <= cnt_q - 1'b1;
  end

  assign pulse = (cnt_q == '0);

  // R2: pulse is one cycle wide
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R2: between pulses the count falls by one each clock
  a_r2_countdown: assert property (@(posedge clk) disable iff (rst)
    !pulse |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8: a new period is never shorter than the floor
  a_r8_floor: assert property (@(posedge clk) disable iff (rst)
    pulse |=> (cnt_q >= FLOOR_CNT));

endmodule

// File: rtl/frac_n_fb_div.sv
module frac_n_fb_div import fnd_pkg::*; #(
  parameter int unsigned INT_W    = 12,
  parameter int unsigned FRAC_W   = 25,
  parameter int unsigned INT_MIN  = 23,
  parameter int unsigned SAFE_MIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  int_word,
  input  logic [FRAC_W-1:0] frac_word,
  input  logic              load,
  output logic              div_pulse,
  output logic              int_err
);

  localparam int unsigned      CNT_W     = INT_W + 1;
  localparam logic [INT_W-1:0] INT_MIN_V = INT_W'(INT_MIN);

  logic [INT_W-1:0]  eff_int, act_int;
  logic [FRAC_W-1:0] eff_frac, act_frac;
  ofs_t              ofs_next;
  logic [CNT_W-1:0]  rst_count, reload_count;
  logic              boundary;

  assign boundary = div_pulse;

  fnd_ratio_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) regs_i (
    .clk(clk), .rst(rst), .load(load), .boundary(boundary),
    .int_in(int_word), .frac_in(frac_word),
    .eff_int(eff_int), .eff_frac(eff_frac),
    .act_int(act_int), .act_frac(act_frac)
  );

  fnd_mash3 #(.FRAC_W(FRAC_W)) mash_i (
    .clk(clk), .rst(rst), .step(boundary), .frac_in(eff_frac), .ofs_next(ofs_next)
  );

  // First period after reset has zero offset; later ones take the modulator's
  assign rst_count    = CNT_W'(period_len(32'(int_word), ofs_t'(0), SAFE_MIN) - 1);
  assign reload_count = CNT_W'(period_len(32'(eff_int), ofs_next, SAFE_MIN) - 1);

  fnd_cycle_counter #(.CNT_W(CNT_W), .SAFE_MIN(SAFE_MIN)) cnt_i (
    .clk(clk), .rst(rst), .rst_count(rst_count),
    .reload_count(reload_count), .pulse(div_pulse)
  );

  assign int_err = (act_int < INT_MIN_V);

  // R7: the error flag changes only at a period end
  a_r7_err_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(int_err) |-> $past(div_pulse));

  // R5: active zero fraction means plain integer reload
  a_r5_integer_reload: assert property (@(posedge clk) disable iff (rst)
    (boundary && eff_frac == '0 && eff_int >= INT_MIN_V) |=> !div_pulse);

endmodule

// File: tb/frac_n_fb_div_tb_top.sv
module frac_n_fb_div_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] int_word = 12'd40;
  logic [24:0] frac_word = '0;
  logic        load = 1'b0;
  logic        div_pulse, int_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  localparam longint MODV = 64'd33554432;
  localparam int NV = 7;
  localparam int V_INT  [NV] = '{23, 100, 40, 30, 25, 4095, 57};
  localparam int V_FRAC [NV] = '{0, 0, 16777216, 8388608, 33554431, 12345678, 1};
  localparam int V_PER  [NV] = '{64, 32, 256, 256, 256, 8, 64};

  frac_n_fb_div dut_i (
    .clk(clk), .rst(rst), .int_word(int_word), .frac_word(frac_word),
    .load(load), .div_pulse(div_pulse), .int_err(int_err)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic measure(output int len);
    len = 0;
    do begin
      tick();
      len++;
    end while (!div_pulse && len < 6000);
  endtask

  // Reset with given words; returns cycle index of first pulse
  task automatic reset_run(input int iv, input int fv, output int first);
    rst = 1'b1; load = 1'b0;
    int_word = 12'(iv); frac_word = 25'(fv);
    repeat (3) tick();
    check("R1 pulse low in reset", longint'(div_pulse), 0);
    rst = 1'b0;
    first = 1;
    while (!div_pulse && first < 6000) begin
      tick();
      first++;
    end
  endtask

  initial begin
    int first, len, bad_rng, bad_zero;
    longint total, diff, expv;

    // Vector table
    for (int v = 0; v < NV; v++) begin
      reset_run(V_INT[v], V_FRAC[v], first);
      check($sformatf("R1 first period vec%0d", v), first, V_INT[v]);
      if (V_INT[v] == 4095) check("R9 long period", first, 4095);
      total = first; bad_rng = 0; bad_zero = 0;
      for (int p = 1; p < V_PER[v]; p++) begin
        measure(len);
        total += len;
        if (len < V_INT[v] - 3 || len > V_INT[v] + 4) bad_rng++;
        if (V_FRAC[v] == 0 && len != V_INT[v]) bad_zero++;
      end
      check($sformatf("R3 periods out of range vec%0d", v), bad_rng, 0);
      if (V_FRAC[v] == 0) check($sformatf("R5 non-integer periods vec%0d", v), bad_zero, 0);
      expv = longint'(V_PER[v]) * V_INT[v] * MODV + longint'(V_PER[v]) * V_FRAC[v];
      diff = total * MODV - expv;
      if (diff < 0) diff = -diff;
      check($sformatf("R4 average within 4 clocks vec%0d (R9 ranges)", v),
            longint'(diff <= 4 * MODV), 1);
    end

    // Reset state of the error flag with a legal word
    rst = 1'b1; int_word = 12'd40; frac_word = '0;
    repeat (2) tick();
    check("R1 int_err low in reset", longint'(int_err), 0);

    // R6: load mid-period does not change the running period
    reset_run(40, 0, first);
    len = 0;
    repeat (10) begin tick(); len++; end
    int_word = 12'd30; load = 1'b1;
    tick(); len++;
    load = 1'b0;
    while (!div_pulse && len < 6000) begin tick(); len++; end
    check("R6 running period kept", len, 40);
    measure(len);
    check("R6 new period applied", len, 30);

    // R6: load in the pulse cycle waits one further period
    int_word = 12'd35; load = 1'b1;
    measure(len);
    load = 1'b0;
    check("R6 pulse-cycle load deferred", len, 30);
    measure(len);
    check("R6 deferred load applied", len, 35);

    // R7/R8: illegal integer word
    tick();
    int_word = 12'd5; load = 1'b1;
    tick();
    load = 1'b0;
    check("R7 flag waits for boundary", longint'(int_err), 0);
    while (!div_pulse) tick();
    check("R7 flag still low in pulse cycle", longint'(int_err), 0);
    measure(len);
    check("R8 floor period", len, 8);
    check("R7 flag high", longint'(int_err), 1);
    tick();
    int_word = 12'd23; load = 1'b1;
    tick();
    load = 1'b0;
    while (!div_pulse) tick();
    measure(len);
    check("R5 legal minimum period", len, 23);
    check("R7 flag cleared", longint'(int_err), 0);

    // R5: nonzero fraction then zero
    reset_run(30, 16777216, first);
    repeat (5) measure(len);
    repeat (3) tick();
    int_word = 12'd30; frac_word = '0; load = 1'b1;
    tick();
    load = 1'b0;
    while (!div_pulse) tick();
    bad_zero = 0;
    for (int p = 0; p < 20; p++) begin
      measure(len);
      if (len != 30) bad_zero++;
    end
    check("R5 integer-N after fraction cleared", bad_zero, 0);

    // R2: pulse lasts one cycle
    tick();
    check("R2 pulse one cycle wide", longint'(div_pulse), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule